// File: doc/BRIEF.md
# Packed SIMD Saturating Subtractor

This block subtracts one 64-bit packed vector from another, lane by lane, in a single registered stage. The vector is split into eight byte lanes, four 16-bit lanes or two 32-bit lanes. In every lane the right operand is taken from the left operand. Each lane then wraps, clamps to the signed range or clamps to the unsigned range, as the mode select chooses.

A per-byte saturation flag shows which lanes clamped. A separate error flag marks the one combination that is not allowed: saturation requested on 32-bit lanes. In that case the block still returns the wrapped difference. A datapath places this block after operand fetch and reads the result one clock after presenting a valid operand pair.

Top module: `psub_sat_unit`

## Requirements
- R1: `lane_sel` sets the lane width: code 0 gives eight 8-bit lanes, code 1 gives four 16-bit lanes, and codes 2 and 3 both give two 32-bit lanes. Lane k covers bits [k*W +: W]. In `mode_sel` codes 0 and 3, each lane holds the low W bits of its difference, and no borrow crosses between lanes.
- R2: Each lane computes `opnd_a` minus `opnd_b`, never the reverse. For example, byte lane 0 with a=0x05 and b=0x03 gives 0x02.
- R3: With `mode_sel` code 1 on 8-bit or 16-bit lanes, a signed difference above the largest signed lane value gives that maximum (0x7F / 0x7FFF). A signed difference below the smallest signed lane value gives that minimum (0x80 / 0x8000). The lane's flag is set when either clamp occurs.
- R4: With `mode_sel` code 2 on 8-bit or 16-bit lanes, a lane where b is greater than a (unsigned) gives zero and sets its flag. Otherwise the lane holds the plain difference, which is never above 0xFF / 0xFFFF.
- R5: 32-bit lanes always give the wrapped difference, and all their saturation flags are 0, whatever the mode.
- R6: `combo_err` is 1 in exactly the output cycle produced from a valid input with a 32-bit lane code (2 or 3) and `mode_sel` code 1 or 2. In all other cycles it is 0.
- R7: `sat_flags` bit i belongs to byte i of the result. For 16-bit and 32-bit lanes, every byte flag inside a lane equals that lane's flag.
- R8: `out_valid` equals `in_valid` delayed by one clock. A synchronous active-high `rst` clears `out_valid`, `result`, `sat_flags` and `combo_err` to 0.
- R9: In a cycle with `in_valid` low, `result` and `sat_flags` keep their previous values, whatever the operands and selects are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and selects are valid this cycle |
| opnd_a | input | 64 | Left operand (minuend) |
| opnd_b | input | 64 | Right operand (subtrahend) |
| lane_sel | input | 2 | Lane width code |
| mode_sel | input | 2 | Arithmetic mode code |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 64 | Packed lane differences |
| sat_flags | output | 8 | Per-byte saturation indicators |
| combo_err | output | 1 | Saturation was requested on 32-bit lanes |

## Verification
The bench checks the clamp boundaries. In signed mode it drives the lowest value minus one and the highest value minus minus-one. A design that tests overflow on the wrong sign pair, or clamps to the wrong rail, returns a wrapped value there or the opposite extreme. It drives an unsigned zero minus one inside a vector. A design whose borrow leaks across lanes corrupts the neighbouring lane, and one that ignores the borrow returns 0xFF instead of zero. It drives every saturation mode on both 32-bit codes. A design that clamps wide lanes, or misses code 3, shows up through a wrong `combo_err` or nonzero flags. Idle cycles with changing operands catch a result register that loads without a valid input.

// File: rtl/psub_pkg.sv
package psub_pkg;

    typedef enum logic [1:0] {
        PW_B8      = 2'd0,
        PW_H16     = 2'd1,
        PW_W32     = 2'd2,
        PW_W32_ALT = 2'd3
    } psub_width_e;

    typedef enum logic [1:0] {
        PM_WRAP     = 2'd0,
        PM_SSAT     = 2'd1,
        PM_USAT     = 2'd2,
        PM_WRAP_ALT = 2'd3
    } psub_mode_e;

    localparam int DATA_W = 64;
    localparam int BYTES  = DATA_W / 8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [BYTES-1:0]  sat;
        logic              err;
    } psub_word_t;

    function automatic logic is_wide(input psub_width_e w);
        return (w == PW_W32) || (w == PW_W32_ALT);
    endfunction

    function automatic logic wants_clamp(input psub_mode_e m);
        return (m == PM_SSAT) || (m == PM_USAT);
    endfunction

    function automatic logic flags_paired(input logic [BYTES-1:0] f, input int grp);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < BYTES; i++) begin
            if (f[i] != f[(i / grp) * grp]) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/psub_lane.sv
module psub_lane #(
    parameter int W      = 8,
    parameter bit SAT_OK = 1'b1
) (
    input  logic [W-1:0]        a,
    input  logic [W-1:0]        b,
    input  psub_pkg::psub_mode_e mode,
    output logic [W-1:0]        res,
    output logic                sat
);
    import psub_pkg::*;

    localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   diff;
    logic [W-1:0] wrapped;
    logic         borrow;
    logic         ovf;

    assign diff    = {1'b0, a} - {1'b0, b};
    assign wrapped = diff[W-1:0];
    assign borrow  = diff[W];
    assign ovf     = (a[W-1] ^ b[W-1]) & (wrapped[W-1] ^ a[W-1]);

    always_comb begin
        res = wrapped;
        sat = 1'b0;
        if (SAT_OK) begin
            case (mode)
                PM_SSAT: if (ovf) begin
                    sat = 1'b1;
                    res = a[W-1] ? S_MIN : S_MAX;
                end
                PM_USAT: if (borrow) begin
                    sat = 1'b1;
                    res = '0;
                end
                default: ;
            endcase
        end
    end

    // R4: unsigned clamp floors to zero whenever the subtrahend is larger
    always_comb begin
        if (SAT_OK && mode == PM_USAT && (a < b))
            a_r4_usat_floor: assert (res == '0 && sat);
    end

    // R3: a signed clamp lands on one of the two rails
    always_comb begin
        if (SAT_OK && mode == PM_SSAT && sat)
            a_r3_ssat_rail: assert (res == S_MAX || res == S_MIN);
    end

endmodule

// File: rtl/psub_stage.sv
module psub_stage (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  psub_pkg::psub_word_t nxt,
    output logic                 vld,
    output psub_pkg::psub_word_t cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= 1'b0;
            cur <= '0;
        end else begin
            vld     <= in_valid;
            cur.err <= in_valid & nxt.err;
            if (in_valid) begin
                cur.data <= nxt.data;
                cur.sat  <= nxt.sat;
            end
        end
    end
endmodule

// File: rtl/psub_sat_unit.sv
module psub_sat_unit (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [63:0] opnd_a,
    input  logic [63:0] opnd_b,
    input  logic [1:0]  lane_sel,
    input  logic [1:0]  mode_sel,
    output logic        out_valid,
    output logic [63:0] result,
    output logic [7:0]  sat_flags,
    output logic        combo_err
);
    import psub_pkg::*;

    localparam int N8  = DATA_W / 8;
    localparam int N16 = DATA_W / 16;
    localparam int N32 = DATA_W / 32;

    psub_width_e width;
    psub_mode_e  mode;
    assign width = psub_width_e'(lane_sel);
    assign mode  = psub_mode_e'(mode_sel);

    logic [DATA_W-1:0] r8, r16, r32;
    logic [N8-1:0]     s8;
    logic [N16-1:0]    s16;
    logic [N32-1:0]    s32;
    logic [BYTES-1:0]  f8, f16, f32;

    for (genvar g = 0; g < N8; g++) begin : g_b8
        psub_lane #(.W(8), .SAT_OK(1'b1)) u_lane (
            .a(opnd_a[g*8 +: 8]), .b(opnd_b[g*8 +: 8]), .mode(mode),
            .res(r8[g*8 +: 8]), .sat(s8[g]));
        assign f8[g] = s8[g];
    end

    for (genvar g = 0; g < N16; g++) begin : g_h16
        psub_lane #(.W(16), .SAT_OK(1'b1)) u_lane (
            .a(opnd_a[g*16 +: 16]), .b(opnd_b[g*16 +: 16]), .mode(mode),
            .res(r16[g*16 +: 16]), .sat(s16[g]));
        assign f16[g*2 +: 2] = {2{s16[g]}};
    end

    for (genvar g = 0; g < N32; g++) begin : g_w32
        psub_lane #(.W(32), .SAT_OK(1'b0)) u_lane (
            .a(opnd_a[g*32 +: 32]), .b(opnd_b[g*32 +: 32]), .mode(mode),
            .res(r32[g*32 +: 32]), .sat(s32[g]));
        assign f32[g*4 +: 4] = {4{s32[g]}};
    end

    psub_word_t nxt, cur;

    always_comb begin
        nxt.err = 1'b0;
        case (width)
            PW_B8:   begin nxt.data = r8;  nxt.sat = f8;  end
            PW_H16:  begin nxt.data = r16; nxt.sat = f16; end
            default: begin
                nxt.data = r32;
                nxt.sat  = f32;
                nxt.err  = wants_clamp(mode);
            end
        endcase
    end

    psub_stage u_stage (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .nxt(nxt), .vld(out_valid), .cur(cur));

    assign result    = cur.data;
    assign sat_flags = cur.sat;
    assign combo_err = cur.err;

    // R8: valid tracks its input one clock later
    a_r8_valid_follow: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r8_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R6: error only after a valid wide-lane clamp request
    a_r6_err_cause: assert property (@(posedge clk) disable iff (rst)
        combo_err |-> out_valid && $past(lane_sel[1])
                     && ($past(mode_sel) == 2'd1 || $past(mode_sel) == 2'd2));

    // R5: wide lanes never report saturation
    a_r5_wide_quiet: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(lane_sel[1]) |-> sat_flags == '0);

    // R7: 16-bit lanes carry identical flags on both bytes
    a_r7_pair_flags: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(lane_sel) == 2'd1 |-> flags_paired(sat_flags, 2));

    // R9: idle cycles leave the data and flags untouched
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result) && $stable(sat_flags));

endmodule

// File: tb/psub_sat_unit_test.sv
module psub_sat_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic [1:0]  lane_sel = '0, mode_sel = '0;
    logic        out_valid, combo_err;
    logic [63:0] result;
    logic [7:0]  sat_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    psub_sat_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .lane_sel(lane_sel), .mode_sel(mode_sel),
        .out_valid(out_valid), .result(result),
        .sat_flags(sat_flags), .combo_err(combo_err));

    // behavioural reference of one operation
    function automatic void ref_op(input logic [63:0] a, input logic [63:0] b,
                                   input logic [1:0] ls, input logic [1:0] md,
                                   output logic [63:0] r, output logic [7:0] f,
                                   output logic e);
        int w, n;
        bit clampable;
        longint mask, half;
        w = (ls == 0) ? 8 : (ls == 1) ? 16 : 32;
        n = 64 / w;
        clampable = (w < 32);
        mask = (longint'(1) <<< w) - 1;
        half = longint'(1) <<< (w - 1);
        r = '0;
        f = '0;
        e = !clampable && (md == 2'd1 || md == 2'd2);
        for (int k = 0; k < n; k++) begin
            longint ua, ub, sa, sb, d, lane;
            bit hit;
            ua = longint'((a >> (k * w))) & mask;
            ub = longint'((b >> (k * w))) & mask;
            sa = (ua >= half) ? ua - (mask + 1) : ua;
            sb = (ub >= half) ? ub - (mask + 1) : ub;
            hit = 1'b0;
            lane = (ua - ub) & mask;
            if (clampable && md == 2'd1) begin
                d = sa - sb;
                if (d > half - 1) begin lane = half - 1; hit = 1'b1; end
                else if (d < -half) begin lane = half; hit = 1'b1; end
            end else if (clampable && md == 2'd2) begin
                if (ua < ub) begin lane = 0; hit = 1'b1; end
            end
            r = r | (64'(lane) << (k * w));
            if (hit)
                for (int j = 0; j < w / 8; j++) f[k * (w / 8) + j] = 1'b1;
        end
    endfunction

    function automatic string tag_of(input logic [1:0] ls, input logic [1:0] md);
        if (ls[1] && (md == 2'd1 || md == 2'd2)) return "R6";
        if (ls[1]) return "R5";
        if (md == 2'd1) return "R3";
        if (md == 2'd2) return "R4";
        return "R1";
    endfunction

    // cycle model
    logic        exp_v, exp_e;
    logic [63:0] exp_r;
    logic [7:0]  exp_f;
    string       exp_tag;
    logic [63:0] t_r;
    logic [7:0]  t_f;
    logic        t_e;

    always @(posedge clk) begin
        if (rst) begin
            exp_v <= 1'b0; exp_e <= 1'b0; exp_r <= '0; exp_f <= '0;
            exp_tag <= "R8";
        end else begin
            exp_v <= in_valid;
            exp_e <= 1'b0;
            if (in_valid) begin
                ref_op(opnd_a, opnd_b, lane_sel, mode_sel, t_r, t_f, t_e);
                exp_r <= t_r; exp_f <= t_f; exp_e <= t_e;
                exp_tag <= tag_of(lane_sel, mode_sel);
            end else begin
                exp_tag <= "R9";
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // compare every output against the model at the falling edge
    task automatic compare_all();
        chk("R8", 64'(out_valid), 64'(exp_v));
        chk(exp_tag, result, exp_r);
        chk(exp_tag == "R9" ? "R9" : "R7", 64'(sat_flags), 64'(exp_f));
        chk("R6", 64'(combo_err), 64'(exp_e));
    endtask

    task automatic step(input logic v, input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] ls, input logic [1:0] md);
        @(negedge clk);
        compare_all();
        in_valid = v; opnd_a = a; opnd_b = b; lane_sel = ls; mode_sel = md;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        chk("R8", 64'(out_valid), 64'd0);
        chk("R8", result, 64'd0);
        chk("R8", 64'(sat_flags), 64'd0);
        chk("R6", 64'(combo_err), 64'd0);

        // R2 direction, byte lanes wrap
        step(1, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0003, 2'd0, 2'd0);
        @(negedge clk);
        chk("R2", result, 64'h0000_0000_0000_0002);
        in_valid = 1'b0;
        // R1 no borrow across byte lanes
        step(1, 64'h7A6A_5A4A_3A2A_1A00, 64'h0000_0000_0000_0001, 2'd0, 2'd0);
        step(1, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 2'd1, 2'd3);
        // R3 signed byte and word rails
        step(1, 64'h807F_0080_7F00_8000, 64'h01FF_0001_FF00_0100, 2'd0, 2'd1);
        step(1, 64'h8000_7FFF_1234_0000, 64'h0001_FFFF_1234_0001, 2'd1, 2'd1);
        // R4 unsigned floor
        step(1, 64'h1020_FF00_0000_3344, 64'h2010_00FF_0001_3344, 2'd0, 2'd2);
        step(1, 64'h0000_FFFF_0001_8000, 64'h0001_0000_0002_7FFF, 2'd1, 2'd2);
        // R5/R6 wide lanes with every mode on both codes
        for (int c = 2; c < 4; c++)
            for (int m = 0; m < 4; m++)
                step(1, 64'h0000_0000_8000_0000, 64'h0000_0001_0000_0001,
                     2'(c), 2'(m));
        // R9 idle with changing inputs
        step(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 2'd0, 2'd1);
        step(0, 64'h0, 64'hFFFF, 2'd3, 2'd2);
        // broad sweep
        for (int i = 0; i < 600; i++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if (i % 5 == 0) b = a ^ 64'h8080_8080_8080_8080;
            step(($urandom % 4) != 0, a, b, 2'($urandom), 2'($urandom));
        end
        // R8 synchronous reset mid-run
        step(1, 64'h1, 64'h2, 2'd0, 2'd2);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        chk("R8", 64'(out_valid), 64'd0);
        chk("R8", result, 64'd0);
        step(1, 64'h0080_0000_0000_0000, 64'h0001_0000_0000_0000, 2'd0, 2'd1);
        step(0, 64'h0, 64'h0, 2'd0, 2'd0);
        step(0, 64'h0, 64'h0, 2'd0, 2'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule